// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the entry sequence for exceptions on a small 32-bit core with a three-stage pipeline (fetch, decode, execute). Seven request lines come in, one per exception kind. The block applies the interrupt masks held in the current status word and picks the winner by a fixed priority. In the next clock cycle it issues one set of write strobes that carries out the whole entry:

- the old status word goes to the saved-status bank of the target mode;
- a link value goes to the link bank of that mode;
- a rewritten status word goes to the live status register;
- the vector address goes to the program counter.

The block also reports the amount that the handler must subtract from the link value on return.

The core's register file, decoder and memory port sit outside this block. The block only drives their write ports. It keeps no architectural state of its own. The status word and the address of the instruction in execute are inputs that the core supplies every cycle.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `enter_o`, every write strobe and every data output are 0. Asserting `rst_n` low clears them at once, without waiting for a clock edge.
- R2: Request bits are `req_i[0]` reset, `[1]` undefined instruction, `[2]` software interrupt, `[3]` prefetch abort, `[4]` data abort, `[5]` IRQ and `[6]` FIQ. `cause_o` reports the winner as its bit index. The priority runs reset > data abort > FIQ > IRQ > prefetch abort > undefined > software interrupt.
- R3: An IRQ request is ignored while `status_i[7]` is 1. An FIQ request is ignored while `status_i[6]` is 1. A lower-priority request that is pending at the same time then wins.
- R4: A request sampled at a rising edge produces its outputs after that same edge, for one cycle. A cycle with no accepted request leaves `enter_o` and all strobes at 0.
- R5: On entry, `spsr_data_o` equals the `status_i` value that was sampled, and `spsr_we_o` is 1. A reset entry writes neither the saved status nor the link.
- R6: The new status word keeps `status_i`, with these changes: bits [4:0] take the target mode, bit 5 (2-byte instruction state) is cleared, bit 7 is set, and bit 6 is set only for FIQ and reset entries.
- R7: The target mode appears on `bank_mode_o` and in the new status word: 0x13 for reset and software interrupt, 0x1B for undefined, 0x17 for both aborts, 0x12 for IRQ and 0x11 for FIQ.
- R8: The link value is the sampled `exec_addr_i` + 4 for undefined, software interrupt and prefetch abort. It is `exec_addr_i` + 8 for IRQ, FIQ and data abort, because the pipeline has already advanced one instruction for those.
- R9: `pc_o` (with `pc_we_o` = 1) is `VEC_BASE` plus the offset for the exception: 0x00 reset, 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 IRQ, 0x1C FIQ.
- R10: `ret_adj_o` is 0 for reset, undefined and software interrupt, 4 for IRQ, FIQ and prefetch abort, and 8 for data abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of this block |
| req_i | input | 7 | Exception request lines, one bit per kind |
| status_i | input | 32 | Current status word of the core |
| exec_addr_i | input | 32 | Address of the instruction in the execute stage |
| enter_o | output | 1 | An entry sequence is being issued this cycle |
| cause_o | output | 3 | Index of the exception being entered |
| bank_mode_o | output | 5 | Target mode; selects the saved-status and link banks |
| spsr_we_o | output | 1 | Write strobe for the banked saved status |
| spsr_data_o | output | 32 | Value for the banked saved status |
| lr_we_o | output | 1 | Write strobe for the banked link register |
| lr_data_o | output | 32 | Link value |
| status_we_o | output | 1 | Write strobe for the live status register |
| status_o | output | 32 | New status word |
| pc_we_o | output | 1 | Program counter load strobe |
| pc_o | output | 32 | Vector address |
| ret_adj_o | output | 4 | Bytes the handler subtracts from the link on return |

## Verification
The hardest case to reach is a mask that changes the outcome of the priority. This happens when a high-priority interrupt is pending but masked and a lower request must win in its place, or when several sources rise in the same cycle. The stimulus table drives combined request words against status words whose mask bits are set in every combination. Each row pairs its stimulus with the winner that the priority rule selects. Directed sequences then cover back-to-back entries, reset asserted while an entry is on the outputs, and a status word with the 2-byte state bit set.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int NUM_CAUSE  = 7;
    localparam int CAUSE_W    = 3;
    localparam int MODE_W     = 5;
    localparam int SLOT_W     = 3;
    localparam int SLOT_SHIFT = 2;
    localparam int ADJ_W      = 4;
    localparam int INSN_BYTES = 4;

    localparam int BIT_HALF   = 5;
    localparam int BIT_FMASK  = 6;
    localparam int BIT_IMASK  = 7;

    typedef enum logic [CAUSE_W-1:0] {
        C_RST = 3'd0,
        C_UND = 3'd1,
        C_SWI = 3'd2,
        C_PAB = 3'd3,
        C_DAB = 3'd4,
        C_IRQ = 3'd5,
        C_FIQ = 3'd6
    } cause_e;

    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [SLOT_W-1:0] slot;
        logic [ADJ_W-1:0]  adj;
        logic              advanced;
        logic              set_fmask;
        logic              save;
    } cause_attr_t;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic [NUM_CAUSE-1:0] req_i,
    input  logic                 irq_masked_i,
    input  logic                 fiq_masked_i,
    output logic                 valid_o,
    output cause_e               cause_o
);

    localparam cause_e RANK [NUM_CAUSE] = '{C_RST, C_DAB, C_FIQ, C_IRQ, C_PAB, C_UND, C_SWI};

    logic [NUM_CAUSE-1:0] live;

    always_comb begin
        live = req_i;
        if (irq_masked_i) live[C_IRQ] = 1'b0;
        if (fiq_masked_i) live[C_FIQ] = 1'b0;
    end

    always_comb begin
        valid_o = 1'b0;
        cause_o = C_RST;
        for (int i = NUM_CAUSE - 1; i >= 0; i--) begin
            if (live[RANK[i]]) begin
                valid_o = 1'b1;
                cause_o = RANK[i];
            end
        end
    end

endmodule

// File: rtl/exc_cause_map.sv
module exc_cause_map
    import exc_pkg::*;
(
    input  cause_e      cause_i,
    output cause_attr_t attr_o
);

    always_comb begin
        attr_o = '0;
        attr_o.save = 1'b1;
        unique case (cause_i)
            C_RST: begin
                attr_o.mode      = MODE_SVC;
                attr_o.slot      = 3'd0;
                attr_o.set_fmask = 1'b1;
                attr_o.save      = 1'b0;
            end
            C_UND: begin
                attr_o.mode = MODE_UND;
                attr_o.slot = 3'd1;
            end
            C_SWI: begin
                attr_o.mode = MODE_SVC;
                attr_o.slot = 3'd2;
            end
            C_PAB: begin
                attr_o.mode = MODE_ABT;
                attr_o.slot = 3'd3;
                attr_o.adj  = ADJ_W'(INSN_BYTES);
            end
            C_DAB: begin
                attr_o.mode     = MODE_ABT;
                attr_o.slot     = 3'd4;
                attr_o.adj      = ADJ_W'(2 * INSN_BYTES);
                attr_o.advanced = 1'b1;
            end
            C_IRQ: begin
                attr_o.mode     = MODE_IRQ;
                attr_o.slot     = 3'd6;
                attr_o.adj      = ADJ_W'(INSN_BYTES);
                attr_o.advanced = 1'b1;
            end
            C_FIQ: begin
                attr_o.mode      = MODE_FIQ;
                attr_o.slot      = 3'd7;
                attr_o.adj       = ADJ_W'(INSN_BYTES);
                attr_o.advanced  = 1'b1;
                attr_o.set_fmask = 1'b1;
            end
            default: attr_o = '0;
        endcase
    end

endmodule

// File: rtl/exc_status_fmt.sv
module exc_status_fmt
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   cur_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              set_fmask_i,
    output logic [XLEN-1:0]   nxt_o
);

    always_comb begin
        nxt_o              = cur_i;
        nxt_o[MODE_W-1:0]  = mode_i;
        nxt_o[BIT_HALF]    = 1'b0;
        nxt_o[BIT_IMASK]   = 1'b1;
        if (set_fmask_i) nxt_o[BIT_FMASK] = 1'b1;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CAUSE-1:0] req_i,
    input  logic [XLEN-1:0]      status_i,
    input  logic [XLEN-1:0]      exec_addr_i,
    output logic                 enter_o,
    output logic [CAUSE_W-1:0]   cause_o,
    output logic [MODE_W-1:0]    bank_mode_o,
    output logic                 spsr_we_o,
    output logic [XLEN-1:0]      spsr_data_o,
    output logic                 lr_we_o,
    output logic [XLEN-1:0]      lr_data_o,
    output logic                 status_we_o,
    output logic [XLEN-1:0]      status_o,
    output logic                 pc_we_o,
    output logic [XLEN-1:0]      pc_o,
    output logic [ADJ_W-1:0]     ret_adj_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    typedef struct packed {
        logic               enter;
        logic [CAUSE_W-1:0] cause;
        logic [MODE_W-1:0]  mode;
        logic               spsr_we;
        logic [XLEN-1:0]    spsr;
        logic               lr_we;
        logic [XLEN-1:0]    lr;
        logic               st_we;
        logic [XLEN-1:0]    st;
        logic               pc_we;
        logic [XLEN-1:0]    pc;
        logic [ADJ_W-1:0]   adj;
    } entry_t;

    logic        arb_valid;
    cause_e      arb_cause;
    cause_attr_t attr;
    logic [XLEN-1:0] fmt_status;
    entry_t ent_d, ent_q;

    exc_arbiter u_arb (
        .req_i        (req_i),
        .irq_masked_i (status_i[BIT_IMASK]),
        .fiq_masked_i (status_i[BIT_FMASK]),
        .valid_o      (arb_valid),
        .cause_o      (arb_cause)
    );

    exc_cause_map u_map (
        .cause_i (arb_cause),
        .attr_o  (attr)
    );

    exc_status_fmt #(.XLEN(XLEN)) u_fmt (
        .cur_i       (status_i),
        .mode_i      (attr.mode),
        .set_fmask_i (attr.set_fmask),
        .nxt_o       (fmt_status)
    );

    always_comb begin
        ent_d = '0;
        if (arb_valid) begin
            ent_d.enter   = 1'b1;
            ent_d.cause   = arb_cause;
            ent_d.mode    = attr.mode;
            ent_d.st_we   = 1'b1;
            ent_d.st      = fmt_status;
            ent_d.pc_we   = 1'b1;
            ent_d.pc      = VEC_BASE + (XLEN'(attr.slot) << SLOT_SHIFT);
            ent_d.adj     = attr.adj;
            if (attr.save) begin
                ent_d.spsr_we = 1'b1;
                ent_d.spsr    = status_i;
                ent_d.lr_we   = 1'b1;
                ent_d.lr      = exec_addr_i + STEP + (attr.advanced ? STEP : '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign enter_o     = ent_q.enter;
    assign cause_o     = ent_q.cause;
    assign bank_mode_o = ent_q.mode;
    assign spsr_we_o   = ent_q.spsr_we;
    assign spsr_data_o = ent_q.spsr;
    assign lr_we_o     = ent_q.lr_we;
    assign lr_data_o   = ent_q.lr;
    assign status_we_o = ent_q.st_we;
    assign status_o    = ent_q.st;
    assign pc_we_o     = ent_q.pc_we;
    assign pc_o        = ent_q.pc;
    assign ret_adj_o   = ent_q.adj;

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [6:0]  req_i,
    input logic [31:0] status_i,
    input logic [31:0] exec_addr_i,
    input logic        enter_o,
    input logic [2:0]  cause_o,
    input logic [4:0]  bank_mode_o,
    input logic        spsr_we_o,
    input logic [31:0] spsr_data_o,
    input logic        lr_we_o,
    input logic [31:0] lr_data_o,
    input logic        status_we_o,
    input logic [31:0] status_o,
    input logic        pc_we_o,
    input logic [31:0] pc_o,
    input logic [3:0]  ret_adj_o
);

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        req_i[0] |=> (enter_o && cause_o == 3'd0)); // R2
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == 7'b0100000 && status_i[7]) |=> !enter_o); // R3
    AST_FIQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == 7'b1000000 && status_i[6]) |=> !enter_o); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == 7'd0) |=> !(enter_o || pc_we_o || status_we_o || lr_we_o || spsr_we_o)); // R4
    AST_SAVED_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        spsr_we_o |-> (spsr_data_o == $past(status_i))); // R5
    AST_RESET_NOSAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_o && cause_o == 3'd0) |-> (!lr_we_o && !spsr_we_o)); // R5
    AST_STATUS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        status_we_o |-> (!status_o[5] && status_o[7] && status_o[4:0] == bank_mode_o)); // R6
    AST_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_o && cause_o == 3'd5) |-> (bank_mode_o == 5'h12)); // R7
    AST_LINK_ADVANCED: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_we_o && (cause_o == 3'd4 || cause_o == 3'd5 || cause_o == 3'd6))
            |-> (lr_data_o == $past(exec_addr_i) + 32'd8)); // R8
    AST_PC_WITH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we_o |-> (enter_o && pc_o[1:0] == 2'b00)); // R9
    AST_DABT_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_o && cause_o == 3'd4) |-> (ret_adj_o == 4'd8)); // R10

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk u_chk (.*);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  req_i = '0;
    logic [31:0] status_i = '0;
    logic [31:0] exec_addr_i = '0;
    logic        enter_o;
    logic [2:0]  cause_o;
    logic [4:0]  bank_mode_o;
    logic        spsr_we_o;
    logic [31:0] spsr_data_o;
    logic        lr_we_o;
    logic [31:0] lr_data_o;
    logic        status_we_o;
    logic [31:0] status_o;
    logic        pc_we_o;
    logic [31:0] pc_o;
    logic [3:0]  ret_adj_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    exc_entry_ctrl uut (.*);

    typedef struct packed {
        logic [6:0]  req;
        logic [31:0] st;
        logic [31:0] ex;
        logic        en;
        logic [2:0]  cause;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{7'b0000100, 32'h0000_0010, 32'h0000_1000, 1'b1, 3'd2},
        '{7'b0000010, 32'h0000_0010, 32'h0000_2004, 1'b1, 3'd1},
        '{7'b0000110, 32'h0000_0010, 32'h0000_2008, 1'b1, 3'd1},
        '{7'b0001010, 32'h0000_0010, 32'h0000_3000, 1'b1, 3'd3},
        '{7'b0100000, 32'h0000_0010, 32'h0000_4000, 1'b1, 3'd5},
        '{7'b0100000, 32'h0000_0090, 32'h0000_4004, 1'b0, 3'd0},
        '{7'b1000000, 32'h0000_0030, 32'h0000_5000, 1'b1, 3'd6},
        '{7'b1000000, 32'h0000_0050, 32'h0000_5004, 1'b0, 3'd0},
        '{7'b1100000, 32'h0000_0050, 32'h0000_5008, 1'b1, 3'd5},
        '{7'b1100000, 32'h0000_0010, 32'h0000_500C, 1'b1, 3'd6},
        '{7'b1010000, 32'h0000_0010, 32'h0000_6000, 1'b1, 3'd4},
        '{7'b1111111, 32'h0000_0010, 32'h0000_7000, 1'b1, 3'd0},
        '{7'b0000000, 32'h0000_0010, 32'h0000_7004, 1'b0, 3'd0},
        '{7'b0010000, 32'hF000_0030, 32'h0000_8000, 1'b1, 3'd4},
        '{7'b0101000, 32'h0000_0013, 32'h0000_9000, 1'b1, 3'd5},
        '{7'b1101100, 32'h0000_00D0, 32'h0000_A000, 1'b1, 3'd3}
    };

    function automatic logic [4:0] m_mode(logic [2:0] c);
        case (c)
            3'd0, 3'd2: return 5'h13;
            3'd1:       return 5'h1B;
            3'd3, 3'd4: return 5'h17;
            3'd5:       return 5'h12;
            default:    return 5'h11;
        endcase
    endfunction

    function automatic logic [31:0] m_vec(logic [2:0] c);
        case (c)
            3'd0: return 32'h00;
            3'd1: return 32'h04;
            3'd2: return 32'h08;
            3'd3: return 32'h0C;
            3'd4: return 32'h10;
            3'd5: return 32'h18;
            default: return 32'h1C;
        endcase
    endfunction

    function automatic logic [3:0] m_adj(logic [2:0] c);
        if (c == 3'd4) return 4'd8;
        if (c == 3'd3 || c == 3'd5 || c == 3'd6) return 4'd4;
        return 4'd0;
    endfunction

    function automatic logic [31:0] m_link(logic [2:0] c, logic [31:0] ex);
        return (c >= 3'd4) ? ex + 32'd8 : ex + 32'd4;
    endfunction

    function automatic logic [31:0] m_status(logic [2:0] c, logic [31:0] st);
        logic [31:0] r;
        r = st;
        r[4:0] = m_mode(c);
        r[5] = 1'b0;
        r[7] = 1'b1;
        if (c == 3'd0 || c == 3'd6) r[6] = 1'b1;
        return r;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_idle(string tag);
        chk(tag, "enter", 32'(enter_o), 32'd0);
        chk(tag, "strobes", {28'd0, spsr_we_o, lr_we_o, status_we_o, pc_we_o}, 32'd0);
    endtask

    task automatic chk_entry(vec_t v);
        if (!v.en) begin
            chk("R3/R4", "no entry", 32'(enter_o), 32'd0);
            chk("R4", "strobes", {28'd0, spsr_we_o, lr_we_o, status_we_o, pc_we_o}, 32'd0);
            return;
        end
        chk("R4", "enter", 32'(enter_o), 32'd1);
        chk("R2", "cause", 32'(cause_o), 32'(v.cause));
        chk("R7", "bank mode", 32'(bank_mode_o), 32'(m_mode(v.cause)));
        chk("R6", "status", status_o, m_status(v.cause, v.st));
        chk("R6", "status we", 32'(status_we_o), 32'd1);
        chk("R9", "pc", pc_o, m_vec(v.cause));
        chk("R9", "pc we", 32'(pc_we_o), 32'd1);
        chk("R10", "ret adj", 32'(ret_adj_o), 32'(m_adj(v.cause)));
        if (v.cause == 3'd0) begin
            chk("R5", "reset saves", {30'd0, spsr_we_o, lr_we_o}, 32'd0);
        end else begin
            chk("R5", "saved we", 32'(spsr_we_o), 32'd1);
            chk("R5", "saved data", spsr_data_o, v.st);
            chk("R8", "link we", 32'(lr_we_o), 32'd1);
            chk("R8", "link", lr_data_o, m_link(v.cause, v.ex));
        end
    endtask

    task automatic drive(logic [6:0] r, logic [31:0] s, logic [31:0] e);
        @(negedge clk);
        req_i = r;
        status_i = s;
        exec_addr_i = e;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: held in reset
        chk_idle("R1");
        chk("R1", "pc", pc_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].req, TBL[i].st, TBL[i].ex);
            @(negedge clk);
            chk_entry(TBL[i]);
        end

        // R4: back-to-back entries, then idle
        drive(7'b0000100, 32'h10, 32'h100);
        drive(7'b0100000, 32'h10, 32'h200);
        chk("R4", "first cause", 32'(cause_o), 32'd2);
        chk("R8", "first link", lr_data_o, 32'h104);
        drive(7'b0000000, 32'h10, 32'h300);
        chk("R4", "second cause", 32'(cause_o), 32'd5);
        chk("R8", "second link", lr_data_o, 32'h208);
        @(negedge clk);
        chk_idle("R4");

        // R1: asynchronous clear while an entry is on the outputs
        drive(7'b0010000, 32'h10, 32'h400);
        @(negedge clk);
        chk("R1", "pre-reset enter", 32'(enter_o), 32'd1);
        rst_n = 1'b0;
        #1;
        chk_idle("R1");
        chk("R1", "link cleared", lr_data_o, 32'd0);
        req_i = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule